// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This block moves a block of bytes between one peripheral and memory so that the CPU does not have to copy each byte itself. The CPU first programs three registers while the block acts as a simple slave: a memory pointer, a count of bytes still to move, and a control/status word. Setting the go bit hands control to the engine. From then on the block acts as a bus master. It raises a bus request when the device signals that it has data or room, waits for the arbiter's grant, and then moves bytes.

Each byte takes two bus cycles. The first cycle reads the source and keeps the byte in an internal holding register. The second cycle writes that byte to the destination. The direction bit selects which side is the source. After every byte the pointer steps up or down and the count drops by one.

In single mode the bus is given back after every byte. In burst mode the engine keeps the bus for as long as the device keeps requesting, but never for more than a fixed run of bytes. When the count reaches zero the engine goes idle, sets a done flag, and raises the interrupt line if interrupts are enabled.

Top module: `dmac_top`

## Requirements
- R1: After reset the pointer, the count and every control bit read as zero, and `bus_req` and `irq` are low.
- R2: Register select 0 reads and writes the pointer, select 1 the count and select 2 the control word. The control word bits are: bit 1 burst mode, bit 2 memory-to-device direction, bit 3 step down, bit 4 interrupt enable, bit 5 busy (read-only), bit 6 done (read-only, write 1 to clear). Bit 0 is go, which reads as 0.
- R3: Writing the control word with bit 0 set, while the count is non-zero, sets busy. With a zero count the go bit has no effect.
- R4: While busy is set, every CPU register write is ignored.
- R5: While busy, `bus_req` rises only after `dev_req` is seen high. It then stays high until `bus_grant` arrives. No memory or device strobe is issued without both request and grant.
- R6: Each byte takes two cycles. The first cycle is a source read, from the device when bit 2 is 0 and from memory when bit 2 is 1. The next cycle writes the held byte to the other side.
- R7: After each byte the pointer is incremented, or decremented when bit 3 is set, and the count is decremented by one.
- R8: In single mode (bit 1 = 0) exactly one byte moves per grant, and `bus_req` is low in the cycle after the write.
- R9: In burst mode, bytes continue under one grant while `dev_req` is high and the count is non-zero, up to MAX_RUN (16) bytes per grant.
- R10: When the count reaches zero, busy clears and the done bit sets. `irq` is high exactly when done and interrupt enable are both set.
- R11: Writing the control word with bit 6 set clears the done bit, and with it `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_sel | input | 2 | CPU register select |
| cfg_wdata | input | AW | CPU write data |
| cfg_rdata | output | AW | CPU read data for the selected register |
| dev_req | input | 1 | Device has data or room |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_rdata | input | DW | Byte from the device |
| dev_wdata | output | DW | Byte to the device |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| mem_addr | output | AW | Memory address (the pointer) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Byte from memory |
| mem_wdata | output | DW | Byte to memory |
| irq | output | 1 | Interrupt request |

## Verification
Block completion and the burst run limit can both happen on the same write cycle. This occurs when the block length is an exact multiple of the run limit. Burst vectors of exactly 16 and 32 bytes provoke this case. They are judged by counting bus-request rises, which must equal the length divided by 16 with no extra request after completion, and by checking that busy clears, the count reads zero and the done bit sets. A second overlap is a CPU write arriving while a block is held waiting for a device request. That write must leave the pointer unchanged.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ARB   = 2'd1,
        ST_FETCH = 2'd2,
        ST_STORE = 2'd3
    } xfer_st_e;

    localparam int SEL_PTR  = 0;
    localparam int SEL_CNT  = 1;
    localparam int SEL_CTRL = 2;

    localparam int CB_GO    = 0;
    localparam int CB_BURST = 1;
    localparam int CB_M2D   = 2;
    localparam int CB_DOWN  = 3;
    localparam int CB_IE    = 4;
    localparam int CB_BUSY  = 5;
    localparam int CB_DONE  = 6;

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] cnt,
    output logic          burst,
    output logic          m2d,
    output logic          down,
    output logic          busy,
    output logic          irq
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [CW-1:0] cnt;
        logic          burst;
        logic          m2d;
        logic          down;
        logic          ie;
        logic          busy;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (!r_q.busy && cfg_we) begin
            unique case (cfg_sel)
                2'(SEL_PTR):  r_d.ptr = cfg_wdata;
                2'(SEL_CNT):  r_d.cnt = CW'(cfg_wdata);
                2'(SEL_CTRL): begin
                    r_d.burst = cfg_wdata[CB_BURST];
                    r_d.m2d   = cfg_wdata[CB_M2D];
                    r_d.down  = cfg_wdata[CB_DOWN];
                    r_d.ie    = cfg_wdata[CB_IE];
                    if (cfg_wdata[CB_DONE])
                        r_d.done = 1'b0;
                    if (cfg_wdata[CB_GO] && (r_q.cnt != '0))
                        r_d.busy = 1'b1;
                end
                default: ;
            endcase
        end
        if (r_q.busy && step) begin
            r_d.ptr = r_q.down ? (r_q.ptr - AW'(1)) : (r_q.ptr + AW'(1));
            r_d.cnt = r_q.cnt - CW'(1);
            if (r_q.cnt == CW'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (cfg_sel)
            2'(SEL_PTR):  cfg_rdata = r_q.ptr;
            2'(SEL_CNT):  cfg_rdata = AW'(r_q.cnt);
            2'(SEL_CTRL): cfg_rdata = AW'({r_q.done, r_q.busy, r_q.ie, r_q.down,
                                           r_q.m2d, r_q.burst, 1'b0});
            default:      cfg_rdata = '0;
        endcase
    end

    assign ptr   = r_q.ptr;
    assign cnt   = r_q.cnt;
    assign burst = r_q.burst;
    assign m2d   = r_q.m2d;
    assign down  = r_q.down;
    assign busy  = r_q.busy;
    assign irq   = r_q.done & r_q.ie;

endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
    import dmac_pkg::*;
#(
    parameter int CW      = 16,
    parameter int DW      = 8,
    parameter int MAX_RUN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          burst,
    input  logic          m2d,
    input  logic [CW-1:0] cnt,
    input  logic          dev_req,
    input  logic          bus_grant,
    input  logic [DW-1:0] dev_rdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          bus_req,
    output logic          step,
    output logic          dev_rd,
    output logic          dev_wr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] dev_wdata,
    output logic [DW-1:0] mem_wdata
);

    localparam int RUN_W = $clog2(MAX_RUN + 1);

    typedef struct packed {
        xfer_st_e      st;
        logic [DW-1:0] hold;
        logic [RUN_W-1:0] run;
    } eng_t;

    eng_t e_q, e_d;

    always_comb begin
        e_d       = e_q;
        step      = 1'b0;
        dev_rd    = 1'b0;
        dev_wr    = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        bus_req   = (e_q.st != ST_WAIT);
        dev_wdata = e_q.hold;
        mem_wdata = e_q.hold;
        unique case (e_q.st)
            ST_WAIT: begin
                if (busy && dev_req) e_d.st = ST_ARB;
            end
            ST_ARB: begin
                if (bus_grant) begin
                    e_d.st  = ST_FETCH;
                    e_d.run = '0;
                end
            end
            ST_FETCH: begin
                if (m2d) begin
                    mem_rd     = 1'b1;
                    e_d.hold   = mem_rdata;
                end else begin
                    dev_rd     = 1'b1;
                    e_d.hold   = dev_rdata;
                end
                e_d.st = ST_STORE;
            end
            ST_STORE: begin
                mem_wr  = !m2d;
                dev_wr  = m2d;
                step    = 1'b1;
                e_d.run = e_q.run + RUN_W'(1);
                if (cnt == CW'(1))
                    e_d.st = ST_WAIT;
                else if (burst && dev_req && (e_d.run < RUN_W'(MAX_RUN)))
                    e_d.st = ST_FETCH;
                else
                    e_d.st = ST_WAIT;
            end
            default: e_d.st = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '{st: ST_WAIT, hold: '0, run: '0};
        else        e_q <= e_d;
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 16,
    parameter int DW      = 8,
    parameter int MAX_RUN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic          dev_req,
    output logic          dev_rd,
    output logic          dev_wr,
    input  logic [DW-1:0] dev_rdata,
    output logic [DW-1:0] dev_wdata,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          irq
);

    logic          step_w;
    logic [CW-1:0] cnt_w;
    logic          burst_w;
    logic          m2d_w;
    logic          down_w;
    logic          busy_w;

    dmac_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .step      (step_w),
        .ptr       (mem_addr),
        .cnt       (cnt_w),
        .burst     (burst_w),
        .m2d       (m2d_w),
        .down      (down_w),
        .busy      (busy_w),
        .irq       (irq)
    );

    dmac_engine #(.CW(CW), .DW(DW), .MAX_RUN(MAX_RUN)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy_w),
        .burst     (burst_w),
        .m2d       (m2d_w),
        .cnt       (cnt_w),
        .dev_req   (dev_req),
        .bus_grant (bus_grant),
        .dev_rdata (dev_rdata),
        .mem_rdata (mem_rdata),
        .bus_req   (bus_req),
        .step      (step_w),
        .dev_rd    (dev_rd),
        .dev_wr    (dev_wr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .dev_wdata (dev_wdata),
        .mem_wdata (mem_wdata)
    );

    logic unused_down;
    assign unused_down = down_w;

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int CW      = 16,
    parameter int DW      = 8,
    parameter int MAX_RUN = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_req,
    input logic          bus_grant,
    input logic          dev_rd,
    input logic          dev_wr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] dev_rdata,
    input logic [DW-1:0] dev_wdata,
    input logic [DW-1:0] mem_rdata,
    input logic [DW-1:0] mem_wdata,
    input logic          busy,
    input logic          burst,
    input logic [CW-1:0] cnt
);

    localparam int TW = $clog2(MAX_RUN + 2);

    logic [TW-1:0] tenure_q;
    logic          store;

    assign store = mem_wr | dev_wr;

    always_ff @(posedge clk) begin
        if (!rst_n || !bus_req) tenure_q <= '0;
        else if (store)         tenure_q <= tenure_q + TW'(1);
    end

    assert_access_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd | mem_wr | dev_rd | dev_wr) |-> (bus_req && bus_grant));

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr, dev_rd, dev_wr}));

    assert_fetch_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> $past(mem_rd | dev_rd));

    assert_mem_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata == $past(dev_rdata)));

    assert_dev_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (dev_wdata == $past(mem_rdata)));

    assert_single_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !burst) |=> !bus_req);

    assert_run_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_q <= TW'(MAX_RUN));

    assert_done_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '0));

endmodule

bind dmac_top dmac_checker #(.CW(CW), .DW(DW), .MAX_RUN(MAX_RUN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .dev_rd    (dev_rd),
    .dev_wr    (dev_wr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .dev_rdata (dev_rdata),
    .dev_wdata (dev_wdata),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .busy      (busy_w),
    .burst     (burst_w),
    .cnt       (cnt_w)
);

// File: tb/dmac_top_tb.sv
module dmac_top_tb;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef struct packed {
        logic        burst;
        logic        m2d;
        logic        down;
        logic        ie;
        logic [7:0]  len;
        logic [15:0] base;
        logic [7:0]  grants;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd5,  16'h0010, 8'd5},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 16'h0040, 8'd2},
        '{1'b1, 1'b1, 1'b1, 1'b0, 8'd32, 16'h00F0, 8'd2},
        '{1'b0, 1'b1, 1'b1, 1'b1, 8'd3,  16'h0080, 8'd3},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd16, 16'h0020, 8'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 8'd40, 16'h00B0, 8'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          dev_req = 1'b0;
    logic          dev_rd, dev_wr;
    logic [DW-1:0] dev_rdata, dev_wdata;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_rdata, mem_wdata;
    logic          irq;

    logic [7:0] mem [256];
    logic [7:0] dev_log [64];
    logic [7:0] dev_rcnt = '0;
    logic [7:0] dev_wcnt = '0;
    logic [7:0] grant_cnt = '0;
    logic       req_prev = 1'b0;
    logic       fill_now = 1'b0;
    logic       grant_block = 1'b0;
    logic       finished = 1'b0;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_req(dev_req),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_rdata(dev_rdata),
        .dev_wdata(dev_wdata), .bus_req(bus_req), .bus_grant(bus_grant),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = 8'hA0 ^ dev_rcnt;

    always @(posedge clk) begin
        bus_grant <= rst_n && bus_req && !grant_block;
        req_prev  <= bus_req;
        if (fill_now) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5C;
            dev_rcnt  <= '0;
            dev_wcnt  <= '0;
            grant_cnt <= '0;
        end else begin
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
            if (dev_rd) dev_rcnt <= dev_rcnt + 8'd1;
            if (dev_wr) begin
                dev_log[dev_wcnt[5:0]] <= dev_wdata;
                dev_wcnt <= dev_wcnt + 8'd1;
            end
            if (bus_req && !req_prev) grant_cnt <= grant_cnt + 8'd1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [AW-1:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [AW-1:0] c;
        for (int k = 0; k < 3000; k++) begin
            rd_reg(2'd2, c);
            if (!c[5]) break;
        end
    endtask

    task automatic clear_models();
        @(negedge clk); fill_now = 1'b1;
        @(negedge clk); fill_now = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] r;
        logic [7:0]    a;
        logic [7:0]    ex;
        int            bad;
        clear_models();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_reg(2'd0, r); chk("R1 ptr", r, 0);
        rd_reg(2'd1, r); chk("R1 cnt", r, 0);
        rd_reg(2'd2, r); chk("R1 ctrl", r, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 irq", irq, 0);

        // R2: readback of registers, go reads as 0
        wr_reg(2'd0, 16'h1234); rd_reg(2'd0, r); chk("R2 ptr", r, 16'h1234);
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd2, 16'h001F); rd_reg(2'd2, r); chk("R2 ctrl", r, 16'h001E);

        // R3: go with zero count has no effect
        chk("R3 zero count busy", r[5], 0);
        chk("R3 zero count bus_req", bus_req, 0);

        // R3/R4/R5: busy but no device request
        dev_req = 1'b0;
        clear_models();
        wr_reg(2'd0, 16'h0030);
        wr_reg(2'd1, 16'd2);
        wr_reg(2'd2, 16'h0001);
        repeat (10) @(negedge clk);
        chk("R5 no req without dev_req", bus_req, 0);
        rd_reg(2'd2, r); chk("R3 busy set", r[5], 1);
        wr_reg(2'd0, 16'h0099);
        rd_reg(2'd0, r); chk("R4 write ignored while busy", r, 16'h0030);

        // R5: request held while grant withheld
        grant_block = 1'b1;
        dev_req = 1'b1;
        repeat (8) @(negedge clk);
        chk("R5 req held", bus_req, 1);
        rd_reg(2'd1, r); chk("R5 no transfer before grant", r, 2);
        grant_block = 1'b0;
        wait_idle();
        rd_reg(2'd1, r); chk("R10 count zero", r, 0);

        // R10/R11: done bit and clear
        rd_reg(2'd2, r); chk("R10 done set", r[6], 1);
        chk("R10 irq off when ie=0", irq, 0);
        wr_reg(2'd2, 16'h0040);
        rd_reg(2'd2, r); chk("R11 done cleared", r[6], 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            clear_models();
            wr_reg(2'd0, VECS[v].base);
            wr_reg(2'd1, 16'(VECS[v].len));
            wr_reg(2'd2, 16'({VECS[v].ie, VECS[v].down, VECS[v].m2d, VECS[v].burst, 1'b1}));
            wait_idle();
            repeat (3) @(negedge clk);
            rd_reg(2'd0, r);
            chk("R7 final ptr", r, VECS[v].down ? VECS[v].base - 16'(VECS[v].len)
                                                : VECS[v].base + 16'(VECS[v].len));
            rd_reg(2'd1, r); chk("R7 final count", r, 0);
            chk(VECS[v].burst ? "R9 grants" : "R8 grants", grant_cnt, VECS[v].grants);
            chk("R10 irq", irq, VECS[v].ie);
            bad = 0;
            for (int i = 0; i < int'(VECS[v].len); i++) begin
                a = VECS[v].down ? VECS[v].base[7:0] - 8'(i) : VECS[v].base[7:0] + 8'(i);
                if (VECS[v].m2d) begin
                    ex = a ^ 8'h5C;
                    if (dev_log[i] !== ex) bad++;
                end else begin
                    ex = 8'hA0 ^ 8'(i);
                    if (mem[a] !== ex) bad++;
                end
            end
            chk("R6 data moved", bad, 0);
            if (VECS[v].ie) begin
                wr_reg(2'd2, 16'h0040);
                chk("R11 irq cleared", irq, 0);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule